// File: doc/BRIEF.md
# Hamming SEC-DED Codec

This block protects an 11-bit data word with an extended Hamming code. It can correct any single flipped bit and flag any pair of flipped bits. The encoder side is purely combinational. It places the data bits into a 16-bit codeword and computes four inline check bits plus one whole-word parity bit. The decoder side takes a received 16-bit word, which may be damaged. After one clock it returns the repaired data, the 4-bit syndrome, and a flag that says whether a single error was corrected or an uncorrectable double error was seen.

Codeword bits are numbered 0 to 15, and bit i of the codeword is bit i of the bus. The check bits sit at the power-of-two positions 1, 2, 4 and 8. Position 0 carries the whole-word parity. The decoder sorts each word into one of three outcome states: DEC_CLEAN, DEC_SINGLE or DEC_DOUBLE. That state is held in a register, and the flags are decoded from it.

On every clock with `dec_in_valid` high, the outcome register takes one of these transitions:
- → DEC_CLEAN when the syndrome is zero and the overall parity is even.
- → DEC_SINGLE when the overall parity is odd.
- → DEC_DOUBLE when the syndrome is nonzero and the overall parity is even.

Reset forces DEC_CLEAN. With `dec_in_valid` low, the state holds.

Top module: `secded_codec`

## Requirements
- R1: The encoder places data bit d0 at codeword position 3 and the following data bits at positions 5, 6, 7, 9, 10, 11, 12, 13, 14 and 15 in ascending order, so d10 ends up at position 15.
- R2: The check bit at position 2^k (positions 1, 2, 4, 8) makes even parity over every position from 1 to 15 whose index has bit k set, the check bit itself included.
- R3: Position 0 makes the whole 16-bit codeword even parity.
- R4: `enc_out_valid` equals `enc_in_valid` in the same cycle, and `enc_code` is valid in that same cycle.
- R5: When a valid codeword arrives undamaged, the decoder returns the original data with syndrome 0, and both flags are low.
- R6: When exactly one bit at position p in 1..15 is flipped, the decoder returns the original data with syndrome equal to p, `dec_corrected` high and `dec_uncorrectable` low.
- R7: When only position 0 is flipped, the decoder returns the original data with syndrome 0 and `dec_corrected` high.
- R8: When exactly two bits are flipped, `dec_uncorrectable` is high and `dec_corrected` is low. The syndrome is the XOR of the two positions and is nonzero. The data is read from the received word without any correction.
- R9: `dec_out_valid` is high exactly one clock after `dec_in_valid` and low otherwise. The decoder outputs hold their values through cycles without `dec_in_valid`.
- R10: A synchronous active-high `rst` clears `dec_out_valid`, the data, the syndrome and both flags on the next clock. It takes priority over an input arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encoder input qualifier |
| enc_data | input | 11 | Data word to encode |
| enc_out_valid | output | 1 | Encoder output qualifier |
| enc_code | output | 16 | Encoded codeword, bit i is position i |
| dec_in_valid | input | 1 | Decoder input qualifier |
| dec_code | input | 16 | Received codeword |
| dec_out_valid | output | 1 | Decoder result qualifier, one clock later |
| dec_data | output | 11 | Corrected (or raw, on double error) data |
| dec_syndrome | output | 4 | Recomputed check syndrome |
| dec_corrected | output | 1 | Single error was corrected |
| dec_uncorrectable | output | 1 | Double error detected |

## Verification
Two pairs of activities can land in the same cycle. The first pair is encoding and decoding, which run on unrelated words. The second pair is a synchronous reset and a decoder word arriving together. The bench probes the encoder in the same cycle as each decoder word and compares both against its behavioural model. It also raises reset while `dec_in_valid` is high. The expected result there is that the word is dropped: the next cycle shows `dec_out_valid` low and all decoder outputs zero.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int CHK_W  = 4;
    localparam int CODE_W = 1 << CHK_W;
    localparam int DATA_W = CODE_W - 1 - CHK_W;

    typedef enum logic [1:0] {
        DEC_CLEAN  = 2'd0,
        DEC_SINGLE = 2'd1,
        DEC_DOUBLE = 2'd2
    } dec_class_e;

    // Position of the j-th data bit: j-th index in 1..code_w-1 that is not a power of two.
    function automatic int data_pos(input int j, input int code_w);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < code_w; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Positions covered by check k: every index >= 1 with bit k set.
    function automatic logic [255:0] cover_mask(input int k, input int code_w);
        logic [255:0] m;
        m = '0;
        for (int p = 1; p < code_w; p++) begin
            if (((p >> k) & 1) == 1) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder #(
    parameter  int CHK_W  = secded_pkg::CHK_W,
    localparam int CODE_W = 1 << CHK_W,
    localparam int DATA_W = CODE_W - 1 - CHK_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] body;
    logic [CODE_W-1:0] full;
    logic [CHK_W-1:0]  chk;

    always_comb begin
        body = '0;
        for (int j = 0; j < DATA_W; j++) begin
            body[secded_pkg::data_pos(j, CODE_W)] = data[j];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [CODE_W-1:0] MASK = CODE_W'(secded_pkg::cover_mask(k, CODE_W));
        assign chk[k] = ^(body & MASK);
    end

    always_comb begin
        full = body;
        for (int k = 0; k < CHK_W; k++) begin
            full[1 << k] = chk[k];
        end
        code = {full[CODE_W-1:1], ^full[CODE_W-1:1]};
    end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
    parameter  int CHK_W  = secded_pkg::CHK_W,
    localparam int CODE_W = 1 << CHK_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [CHK_W-1:0]  syn,
    output logic              odd
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        localparam logic [CODE_W-1:0] MASK = CODE_W'(secded_pkg::cover_mask(k, CODE_W));
        assign syn[k] = ^(code & MASK);
    end

    assign odd = ^code;

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector #(
    parameter  int CHK_W  = secded_pkg::CHK_W,
    localparam int CODE_W = 1 << CHK_W,
    localparam int DATA_W = CODE_W - 1 - CHK_W
) (
    input  logic [CODE_W-1:0]       code,
    input  logic [CHK_W-1:0]        syn,
    input  logic                    odd,
    output secded_pkg::dec_class_e  cls,
    output logic [DATA_W-1:0]       data
);

    logic [CODE_W-1:0] fixed;

    always_comb begin
        unique case ({odd, |syn})
            2'b00:        cls = secded_pkg::DEC_CLEAN;
            2'b01:        cls = secded_pkg::DEC_DOUBLE;
            2'b10, 2'b11: cls = secded_pkg::DEC_SINGLE;
        endcase
    end

    always_comb begin
        fixed = code;
        if (cls == secded_pkg::DEC_SINGLE) begin
            fixed[syn] = ~code[syn];
        end
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_extract
        localparam int POS = secded_pkg::data_pos(j, CODE_W);
        assign data[j] = fixed[POS];
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
    parameter  int CHK_W  = secded_pkg::CHK_W,
    localparam int CODE_W = 1 << CHK_W,
    localparam int DATA_W = CODE_W - 1 - CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_in_valid,
    input  logic [DATA_W-1:0] enc_data,
    output logic              enc_out_valid,
    output logic [CODE_W-1:0] enc_code,
    input  logic              dec_in_valid,
    input  logic [CODE_W-1:0] dec_code,
    output logic              dec_out_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic [CHK_W-1:0]  dec_syndrome,
    output logic              dec_corrected,
    output logic              dec_uncorrectable
);

    secded_pkg::dec_class_e cls_d, cls_q;
    logic [CHK_W-1:0]  syn_d;
    logic              odd_d;
    logic [DATA_W-1:0] data_d;

    secded_encoder #(.CHK_W(CHK_W)) u_enc (
        .data (enc_data),
        .code (enc_code)
    );

    assign enc_out_valid = enc_in_valid;

    secded_syndrome #(.CHK_W(CHK_W)) u_syn (
        .code (dec_code),
        .syn  (syn_d),
        .odd  (odd_d)
    );

    secded_corrector #(.CHK_W(CHK_W)) u_fix (
        .code (dec_code),
        .syn  (syn_d),
        .odd  (odd_d),
        .cls  (cls_d),
        .data (data_d)
    );

    // Outcome-state register and its companions.
    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q         <= secded_pkg::DEC_CLEAN;
            dec_out_valid <= 1'b0;
            dec_data      <= '0;
            dec_syndrome  <= '0;
        end else begin
            dec_out_valid <= dec_in_valid;
            if (dec_in_valid) begin
                cls_q        <= cls_d;
                dec_data     <= data_d;
                dec_syndrome <= syn_d;
            end
        end
    end

    // Flag decode from the outcome state.
    always_comb begin
        unique case (cls_q)
            secded_pkg::DEC_CLEAN: begin
                dec_corrected     = 1'b0;
                dec_uncorrectable = 1'b0;
            end
            secded_pkg::DEC_SINGLE: begin
                dec_corrected     = 1'b1;
                dec_uncorrectable = 1'b0;
            end
            secded_pkg::DEC_DOUBLE: begin
                dec_corrected     = 1'b0;
                dec_uncorrectable = 1'b1;
            end
            default: begin
                dec_corrected     = 1'b0;
                dec_uncorrectable = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
    parameter  int CHK_W  = secded_pkg::CHK_W,
    localparam int CODE_W = 1 << CHK_W,
    localparam int DATA_W = CODE_W - 1 - CHK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_in_valid,
    input logic [CODE_W-1:0] dec_code,
    input logic              dec_out_valid,
    input logic [DATA_W-1:0] dec_data,
    input logic [CHK_W-1:0]  dec_syndrome,
    input logic              dec_corrected,
    input logic              dec_uncorrectable
);

    // R9
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        dec_in_valid |=> dec_out_valid);

    // R9
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !dec_in_valid |=> !dec_out_valid);

    // R9
    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !dec_in_valid |=> ($stable(dec_data) && $stable(dec_syndrome)
                           && $stable(dec_corrected) && $stable(dec_uncorrectable)));

    // R6
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dec_corrected && dec_uncorrectable));

    // R8
    a_r8_double_syndrome: assert property (@(posedge clk) disable iff (rst)
        dec_uncorrectable |-> (dec_syndrome != '0));

    // R5
    a_r5_clean_syndrome: assert property (@(posedge clk) disable iff (rst)
        (dec_out_valid && !dec_corrected && !dec_uncorrectable) |-> (dec_syndrome == '0));

endmodule

bind secded_codec secded_codec_chk #(.CHK_W(CHK_W)) chk_i (
    .clk               (clk),
    .rst               (rst),
    .dec_in_valid      (dec_in_valid),
    .dec_code          (dec_code),
    .dec_out_valid     (dec_out_valid),
    .dec_data          (dec_data),
    .dec_syndrome      (dec_syndrome),
    .dec_corrected     (dec_corrected),
    .dec_uncorrectable (dec_uncorrectable)
);

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_in_valid = 1'b0;
    logic [10:0] enc_data = '0;
    logic        enc_out_valid;
    logic [15:0] enc_code;
    logic        dec_in_valid = 1'b0;
    logic [15:0] dec_code = '0;
    logic        dec_out_valid;
    logic [10:0] dec_data;
    logic [3:0]  dec_syndrome;
    logic        dec_corrected;
    logic        dec_uncorrectable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        exp_valid = 1'b0;
    logic [10:0] exp_data  = '0;
    logic [3:0]  exp_syn   = '0;
    logic        exp_cor   = 1'b0;
    logic        exp_unc   = 1'b0;
    string       prev_tag  = "R10";

    always #2.5 clk = ~clk;

    secded_codec dut_i (
        .clk               (clk),
        .rst               (rst),
        .enc_in_valid      (enc_in_valid),
        .enc_data          (enc_data),
        .enc_out_valid     (enc_out_valid),
        .enc_code          (enc_code),
        .dec_in_valid      (dec_in_valid),
        .dec_code          (dec_code),
        .dec_out_valid     (dec_out_valid),
        .dec_data          (dec_data),
        .dec_syndrome      (dec_syndrome),
        .dec_corrected     (dec_corrected),
        .dec_uncorrectable (dec_uncorrectable)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural encoder: data into non-power-of-two slots, then parities.
    function automatic logic [15:0] ref_enc(input logic [10:0] d);
        logic [15:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p < 16; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin
                c[p] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 4; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p < 16; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) par = par ^ c[p];
            end
            c[1 << k] = par;
        end
        c[0] = ^c[15:1];
        return c;
    endfunction

    function automatic logic [10:0] ref_extract(input logic [15:0] r);
        logic [10:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p < 16; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8) begin
                d[j] = r[p];
                j++;
            end
        end
        return d;
    endfunction

    // Behavioural decode: syndrome as XOR of the indices of set bits.
    task automatic ref_dec(input logic [15:0] r);
        int s;
        logic [15:0] f;
        s = 0;
        for (int p = 0; p < 16; p++) if (r[p]) s = s ^ p;
        f = r;
        exp_cor = 1'b0;
        exp_unc = 1'b0;
        if (^r) begin
            exp_cor = 1'b1;
            f[s] = ~f[s];
        end else if (s != 0) begin
            exp_unc = 1'b1;
        end
        exp_syn  = 4'(s);
        exp_data = ref_extract(f);
    endtask

    task automatic step(input logic r, input logic v, input logic [15:0] code, input string tag);
        string t;
        @(negedge clk);
        t = exp_valid ? prev_tag : "R9";
        chk(dec_out_valid == exp_valid, "R9 valid", 32'(dec_out_valid), 32'(exp_valid));
        chk(dec_data == exp_data, t, 32'(dec_data), 32'(exp_data));
        chk(dec_syndrome == exp_syn, t, 32'(dec_syndrome), 32'(exp_syn));
        chk(dec_corrected == exp_cor, t, 32'(dec_corrected), 32'(exp_cor));
        chk(dec_uncorrectable == exp_unc, t, 32'(dec_uncorrectable), 32'(exp_unc));
        rst          = r;
        dec_in_valid = v;
        dec_code     = code;
        if (r) begin
            exp_valid = 1'b0;
            exp_data  = '0;
            exp_syn   = '0;
            exp_cor   = 1'b0;
            exp_unc   = 1'b0;
            prev_tag  = "R10";
        end else begin
            exp_valid = v;
            if (v) begin
                ref_dec(code);
                prev_tag = tag;
            end
        end
    endtask

    task automatic enc_probe(input logic [10:0] d);
        logic [15:0] e;
        enc_in_valid = 1'b1;
        enc_data     = d;
        #1;
        e = ref_enc(d);
        chk(enc_out_valid == 1'b1, "R4", 32'(enc_out_valid), 32'd1);
        chk(enc_code == e, "R1/R2", 32'(enc_code), 32'(e));
        chk((^enc_code) == 1'b0, "R3", 32'(^enc_code), 32'd0);
        enc_in_valid = 1'b0;
        #0.5;
        chk(enc_out_valid == 1'b0, "R4", 32'(enc_out_valid), 32'd0);
    endtask

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cw;
        // Reset state, with a word offered during reset (R10).
        step(1'b1, 1'b1, 16'hFFFF, "R10");
        step(1'b1, 1'b0, 16'h0000, "R10");
        step(1'b0, 1'b0, 16'h0000, "R10");
        // Every data value, undamaged, with encoder probed in the same cycle.
        for (int d = 0; d < 2048; d++) begin
            cw = ref_enc(11'(d));
            step(1'b0, 1'b1, cw, "R5");
            enc_probe(11'(d));
            if (d % 7 == 0) step(1'b0, 1'b0, ~cw, "R9");
        end
        // Every single flip, all 16 positions.
        for (int d = 0; d < 2048; d++) begin
            cw = ref_enc(11'(d));
            for (int p = 0; p < 16; p++) begin
                step(1'b0, 1'b1, cw ^ (16'd1 << p), (p == 0) ? "R7" : "R6");
            end
        end
        // Reset colliding with an incoming word (R10).
        step(1'b0, 1'b1, ref_enc(11'h5A5) ^ 16'h0040, "R6");
        step(1'b1, 1'b1, ref_enc(11'h123), "R10");
        step(1'b0, 1'b0, 16'h0000, "R10");
        // Sample of double flips: all pairs on every eighth data value.
        for (int d = 0; d < 2048; d += 8) begin
            cw = ref_enc(11'(d));
            for (int a = 0; a < 16; a++) begin
                for (int b = a + 1; b < 16; b++) begin
                    step(1'b0, 1'b1, cw ^ (16'd1 << a) ^ (16'd1 << b), "R8");
                end
            end
        end
        step(1'b0, 1'b0, 16'h0000, "R9");
        step(1'b0, 1'b0, 16'h0000, "R9");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule